// File: doc/BRIEF.md
# Host Byte-Lane Parity Error Monitor

This block watches a 32-bit host bus data path and checks one extra parity pin per byte lane. Checking happens on every accepted transfer in which the controller either reads as bus master or is written as a slave. The checking cannot be turned off. A lane error is fatal: the block raises a one-cycle stop request to the script sequencer and sets a sticky status bit.

A second sticky status bit records that, while the controller was master, a target signalled a parity error during a data phase. This capture only takes place while a separate master parity checking enable is set. Each status bit has its own interrupt enable. The enable gates only the shared interrupt request and never the status. A read-clear strobe clears both status bits.

The standard bus parity line is generated and checked elsewhere. This block has no port that reaches it.

Top module: `hbp_monitor`

## Requirements
- R1: After reset, `lane_err_sts`, `mdpe_sts`, `irq` and `seq_stop` are all 0.
- R2: Byte lane i is bits `data[8i+7:8i]` together with `lane_par[i]`. The lane is in error when these nine bits hold an even number of ones, because odd parity is required. An error in any lane sets `lane_err_sts` after the next rising clock edge.
- R3: Lanes are checked only in a cycle where `xfer_valid` and `xfer_ready` are both 1 and at least one of `dir_mst_rd` or `dir_slv_wr` is 1. A bad word in any other cycle has no effect.
- R4: The lane check has no enable. With `lane_irq_en`, `mdpe_irq_en` and `mpe_chk_en` all 0, a bad lane still sets `lane_err_sts`.
- R5: A lane error raises `seq_stop` for exactly the one cycle that follows the erroneous transfer.
- R6: `irq` reflects `lane_err_sts` only while `lane_irq_en` is 1. Clearing the enable drops `irq` and leaves the status set.
- R7: `mdpe_sts` sets after the next rising edge when `xfer_valid`, `master_mode`, `target_perr` and `mpe_chk_en` are all 1 in the same cycle.
- R8: With `mpe_chk_en` at 0, a target parity error does not set `mdpe_sts`.
- R9: `irq` reflects `mdpe_sts` only while `mdpe_irq_en` is 1. Clearing the enable leaves the status set.
- R10: `status_rd_clr` clears both status bits at the next edge. If an error of a given kind occurs in the same cycle, that status bit stays set.
- R11: The status bits stay set over idle cycles until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | Data is valid on the bus this cycle |
| xfer_ready | input | 1 | Target is ready this cycle |
| dir_mst_rd | input | 1 | Transfer is a bus-master read |
| dir_slv_wr | input | 1 | Transfer is a slave write |
| data | input | 32 | Bus data, four byte lanes |
| lane_par | input | 4 | Per-lane parity pins |
| master_mode | input | 1 | Controller is bus master this data phase |
| target_perr | input | 1 | Target signals a data parity error |
| mpe_chk_en | input | 1 | Enables capture of master data parity errors |
| lane_irq_en | input | 1 | Interrupt enable for lane parity errors |
| mdpe_irq_en | input | 1 | Interrupt enable for master data parity errors |
| status_rd_clr | input | 1 | Read-clear strobe for both status bits |
| lane_err_sts | output | 1 | Sticky lane parity error status |
| mdpe_sts | output | 1 | Sticky master data parity error status |
| irq | output | 1 | Interrupt request |
| seq_stop | output | 1 | Fatal stop request to the script sequencer |

## Verification
Both status bits and `seq_stop` come from a single register stage. Each is due after the first rising edge that follows the stimulus. `seq_stop` is gone again one edge later. `irq` is a combinational function of the status registers and the enables, so it follows an enable change in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge. Each result is therefore read half a period after the edge that produced it, and `seq_stop` is read again one full cycle later to confirm that it has dropped.

// File: rtl/hbp_monitor.sv
module hbp_monitor #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xfer_valid,
  input  logic                    xfer_ready,
  input  logic                    dir_mst_rd,
  input  logic                    dir_slv_wr,
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        lane_par,
  input  logic                    master_mode,
  input  logic                    target_perr,
  input  logic                    mpe_chk_en,
  input  logic                    lane_irq_en,
  input  logic                    mdpe_irq_en,
  input  logic                    status_rd_clr,
  output logic                    lane_err_sts,
  output logic                    mdpe_sts,
  output logic                    irq,
  output logic                    seq_stop
);

  logic [LANES-1:0] lane_bad;
  logic             lane_qual;
  logic             lane_hit;
  logic             mdpe_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = ~^{data[g*LANE_W +: LANE_W], lane_par[g]};
  end

  assign lane_qual = xfer_valid & xfer_ready & (dir_mst_rd | dir_slv_wr);
  assign lane_hit  = lane_qual & (|lane_bad);
  assign mdpe_hit  = xfer_valid & master_mode & target_perr & mpe_chk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_err_sts <= 1'b0;
      mdpe_sts     <= 1'b0;
      seq_stop     <= 1'b0;
    end else begin
      seq_stop     <= lane_hit;
      lane_err_sts <= lane_hit | (lane_err_sts & ~status_rd_clr);
      mdpe_sts     <= mdpe_hit | (mdpe_sts & ~status_rd_clr);
    end
  end

  assign irq = (lane_err_sts & lane_irq_en) | (mdpe_sts & mdpe_irq_en);

endmodule

module hbp_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_valid,
  input logic xfer_ready,
  input logic dir_mst_rd,
  input logic dir_slv_wr,
  input logic master_mode,
  input logic target_perr,
  input logic mpe_chk_en,
  input logic status_rd_clr,
  input logic lane_err_sts,
  input logic mdpe_sts,
  input logic irq,
  input logic seq_stop
);

  AST_STOP_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stop |-> lane_err_sts); // R5

  AST_LANE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stop |-> $past(xfer_valid && xfer_ready && (dir_mst_rd || dir_slv_wr))); // R3

  AST_MDPE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdpe_sts && !(xfer_valid && master_mode && target_perr && mpe_chk_en)) |=> !mdpe_sts); // R8

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (lane_err_sts || mdpe_sts)); // R6

  AST_LANE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_err_sts && !status_rd_clr) |=> lane_err_sts); // R11

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd_clr && !xfer_valid) |=> (!lane_err_sts && !mdpe_sts)); // R10

endmodule

bind hbp_monitor hbp_monitor_chk u_hbp_monitor_chk (.*);

// File: tb/test_hbp_monitor.sv
module test_hbp_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_valid = 0, xfer_ready = 0, dir_mst_rd = 0, dir_slv_wr = 0;
  logic [31:0] data = '0;
  logic [3:0]  lane_par = '0;
  logic master_mode = 0, target_perr = 0, mpe_chk_en = 0;
  logic lane_irq_en = 0, mdpe_irq_en = 0, status_rd_clr = 0;
  logic lane_err_sts, mdpe_sts, irq, seq_stop;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  hbp_monitor i_hbp_monitor (.*);

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~^d[i*8 +: 8];
    return p;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] d, input logic [3:0] p,
                      input logic v, input logic r, input logic mr, input logic sw);
    @(negedge clk);
    data = d; lane_par = p; xfer_valid = v; xfer_ready = r;
    dir_mst_rd = mr; dir_slv_wr = sw;
    @(negedge clk);
    xfer_valid = 0; xfer_ready = 0; dir_mst_rd = 0; dir_slv_wr = 0;
  endtask

  task automatic clr();
    @(negedge clk);
    status_rd_clr = 1;
    @(negedge clk);
    status_rd_clr = 0;
  endtask

  task automatic t_reset();
    chk(lane_err_sts, 0, "R1 lane_err_sts");
    chk(mdpe_sts, 0, "R1 mdpe_sts");
    chk(irq, 0, "R1 irq");
    chk(seq_stop, 0, "R1 seq_stop");
  endtask

  task automatic t_good_words();
    logic [31:0] w [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F81, 32'h1234_5678};
    for (int i = 0; i < 4; i++) begin
      xfer(w[i], good_par(w[i]), 1, 1, i[0], ~i[0]);
      chk(lane_err_sts, 0, "R2 good word no error");
      chk(seq_stop, 0, "R2 good word no stop");
    end
  endtask

  task automatic t_bad_lanes();
    lane_irq_en = 1;
    for (int l = 0; l < 4; l++) begin
      logic [31:0] d = 32'h3C5A_9617 ^ (32'h1 << (l * 8));
      logic [3:0] p = good_par(d) ^ (4'b1 << l);
      xfer(d, p, 1, 1, l[0], ~l[0]);
      chk(lane_err_sts, 1, "R2 bad lane sets status");
      chk(seq_stop, 1, "R5 stop raised");
      chk(irq, 1, "R6 irq with enable");
      @(negedge clk);
      chk(seq_stop, 0, "R5 stop one cycle");
      clr();
      chk(lane_err_sts, 0, "R10 status cleared");
    end
    lane_irq_en = 0;
  endtask

  task automatic t_qualifiers();
    logic [31:0] d = 32'h0000_0001;
    logic [3:0] p = good_par(d) ^ 4'b0001;
    xfer(d, p, 0, 1, 1, 0);
    chk(lane_err_sts, 0, "R3 ignored without valid");
    xfer(d, p, 1, 0, 1, 0);
    chk(lane_err_sts, 0, "R3 ignored without ready");
    xfer(d, p, 1, 1, 0, 0);
    chk(lane_err_sts, 0, "R3 ignored wrong direction");
    chk(seq_stop, 0, "R3 no stop when ignored");
  endtask

  task automatic t_always_on();
    logic [31:0] d = 32'h8000_0000;
    lane_irq_en = 0; mdpe_irq_en = 0; mpe_chk_en = 0;
    xfer(d, good_par(d) ^ 4'b1000, 1, 1, 1, 0);
    chk(lane_err_sts, 1, "R4 status with all enables off");
    chk(irq, 0, "R6 irq masked");
    repeat (3) @(negedge clk);
    chk(lane_err_sts, 1, "R11 status sticky");
    lane_irq_en = 1;
    #1 chk(irq, 1, "R6 irq after enable");
    lane_irq_en = 0;
    #1 chk(irq, 0, "R6 irq drops on disable");
    chk(lane_err_sts, 1, "R6 status kept");
    clr();
  endtask

  task automatic t_mdpe();
    @(negedge clk);
    xfer_valid = 1; master_mode = 1; target_perr = 1; mpe_chk_en = 0;
    @(negedge clk);
    xfer_valid = 0; target_perr = 0;
    chk(mdpe_sts, 0, "R8 no capture when disabled");
    mpe_chk_en = 1; mdpe_irq_en = 0;
    @(negedge clk);
    xfer_valid = 1; target_perr = 1;
    @(negedge clk);
    xfer_valid = 0; target_perr = 0;
    chk(mdpe_sts, 1, "R7 master data parity captured");
    chk(irq, 0, "R9 irq masked");
    chk(lane_err_sts, 0, "R7 lane status untouched");
    repeat (2) @(negedge clk);
    chk(mdpe_sts, 1, "R11 mdpe sticky");
    mdpe_irq_en = 1;
    #1 chk(irq, 1, "R9 irq after enable");
    clr();
    chk(mdpe_sts, 0, "R10 mdpe cleared");
    chk(irq, 0, "R10 irq gone after clear");
    mdpe_irq_en = 0; master_mode = 0; mpe_chk_en = 0;
  endtask

  task automatic t_clear_collision();
    logic [31:0] d = 32'h00FF_0000;
    @(negedge clk);
    data = d; lane_par = good_par(d) ^ 4'b0100;
    xfer_valid = 1; xfer_ready = 1; dir_slv_wr = 1; status_rd_clr = 1;
    @(negedge clk);
    xfer_valid = 0; xfer_ready = 0; dir_slv_wr = 0; status_rd_clr = 0;
    chk(lane_err_sts, 1, "R10 set wins over clear");
    clr();
    chk(lane_err_sts, 0, "R10 later clear works");
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_good_words();
    t_bad_lanes();
    t_qualifiers();
    t_always_on();
    t_mdpe();
    t_clear_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule